// File: doc/BRIEF.md
# Column-associative data cache

A data cache controller organised as a direct-mapped array of whole lines. Each line may also sit in a second set, the rehashed one. A request port accepts word reads and word writes through a valid/ready handshake. Every access first looks up the set chosen by plain bit selection of the address. In pseudo-associative mode, a miss there may then look in the set whose index differs only in its top bit. A hit in that second set swaps the two lines, so the requested line returns to its home set.

Every set carries one rehash flag. It shows whether the line held there is a guest from its partner set. The flag decides, after a first-look miss, whether a second look is worth making. A refill port fetches whole lines from the next level. A write-back port hands out dirty lines that leave the cache. A mode input turns the cache back into an ordinary direct-mapped cache. Two counters record hits and refills, so software around the block can derive a miss rate.

Top module: `colassoc_cache`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `resp_valid`, `fill_req` and `wb_valid` are 0, both counters are 0, every line is invalid and every rehash flag is 1.
- R2: A request that hits in its home set (index = address bits [12:6] with the default geometry) is answered with `resp_valid` in the cycle after it is accepted. A read returns the stored word (word select = address bits [5:2]). A write replaces that word and marks the line dirty.
- R3: In pseudo-associative mode, if the home-set lookup misses while that set's rehash flag is 1, no second lookup is made. The home set is refilled directly, and the response comes 2 + L cycles after acceptance, where L is the refill latency.
- R4: In pseudo-associative mode, if the home-set lookup misses while its rehash flag is 0, the partner set (home index with its top bit inverted) is examined. If the line is found there, the two sets exchange contents and the response comes 2 cycles after acceptance with the requested word.
- R5: After an exchange, the line that was pushed out of the home set sits in the partner set with its rehash flag at 1. The moved line sits in the home set with its flag at 0. The pushed-out line is therefore still found by a later second lookup.
- R6: When both lookups miss, a valid home-set line moves to the partner set with its rehash flag at 1. A dirty line that was in the partner set is first sent out on the write-back port, at its own line address. The new line is then refilled into the home set with its flag at 0. The response comes 3 + L cycles after acceptance.
- R7: With `pa_mode` at 0 no second lookup is ever made. Every home-set miss refills the home set, after writing back a dirty victim, with the response 2 + L cycles after acceptance.
- R8: `hit_count` increases by one for each home-set or partner-set hit. `miss_count` increases by one for each refill.
- R9: During a refill, `fill_req` stays high with a line-aligned, stable `fill_addr` until `fill_valid`. Writes allocate, and data written back earlier is read again correctly after a refill.
- R10: `req_ready` is 0 from the acceptance of a request that misses in its home set until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pa_mode | input | 1 | 1 = pseudo-associative, 0 = plain direct-mapped; change only while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the word |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | WORD_W | Read data (defined for reads) |
| fill_req | output | 1 | Line fetch request to the next level |
| fill_addr | output | ADDR_W | Line-aligned fetch address |
| fill_valid | input | 1 | One-cycle strobe with the fetched line |
| fill_data | input | LINE_BYTES*8 | Fetched line, word 0 in the low bits |
| wb_valid | output | 1 | One-cycle write-back strobe |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | LINE_BYTES*8 | Written-back line contents |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of refills |

## Verification
Three lines share one home set, and a fourth line has the partner set as its home. With these, the bench drives every path: home hit, partner hit with exchange, double miss with relocation, and direct refill forced by a set rehash flag. The response latency of each access is measured, so the path actually taken is told apart, not only the data. A dirty line is pushed out through the partner set and later read back. This shows that the write-back address and contents are right. The same thrashing pattern is then repeated in direct-mapped mode, where latencies that would have been partner hits must become refills. Back-to-back home hits and a write that allocates on a miss complete the patterns.

// File: rtl/cac_pkg.sv
// Shared types of the column-associative cache.
package cac_pkg;
    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE2,
        ST_SWAP,
        ST_EVICT,
        ST_REFILL
    } cac_state_e;
endpackage

// File: rtl/cac_addr_map.sv
// Address decomposition for the column-associative cache.
// Produces the home set index, the partner index (home index with its top
// bit inverted), the extended tag (tag with the top index bit appended),
// the word select and the line-aligned address. Purely combinational.
// Assumes IDX_W >= 2 and OFF_W >= WSEL_W.
module cac_addr_map #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 7,
    parameter int WSEL_W = 4,
    localparam int ETAG_W = ADDR_W - OFF_W - IDX_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  home_idx,
    output logic [IDX_W-1:0]  alt_idx,
    output logic [ETAG_W-1:0] ext_tag,
    output logic [WSEL_W-1:0] wsel,
    output logic [ADDR_W-1:0] line_addr
);
    localparam int BYTE_SEL_W = OFF_W - WSEL_W;

    logic unused_byte_bits;

    // Field extraction and rehash by top-bit inversion.
    always_comb begin
        home_idx  = addr[OFF_W+IDX_W-1:OFF_W];
        alt_idx   = {~home_idx[IDX_W-1], home_idx[IDX_W-2:0]};
        ext_tag   = {addr[ADDR_W-1:OFF_W+IDX_W], home_idx[IDX_W-1]};
        wsel      = addr[OFF_W-1:BYTE_SEL_W];
        line_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    generate
        if (BYTE_SEL_W > 0) begin : g_bytes
            assign unused_byte_bits = ^addr[(BYTE_SEL_W > 0 ? BYTE_SEL_W : 1)-1:0];
        end else begin : g_nobytes
            assign unused_byte_bits = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cac_line_store.sv
// Tag and data array: one entry {extended tag, line} per set.
// Two combinational read ports and two write ports, so that an exchange of
// two sets completes in one cycle. When both write ports name the same set,
// port 1 wins. The array is not reset; validity lives in the controller.
module cac_line_store #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int ENT_W = 532
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [ENT_W-1:0] rd0_ent,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [ENT_W-1:0] rd1_ent,
    input  logic             wr0_en,
    input  logic [IDX_W-1:0] wr0_idx,
    input  logic [ENT_W-1:0] wr0_ent,
    input  logic             wr1_en,
    input  logic [IDX_W-1:0] wr1_idx,
    input  logic [ENT_W-1:0] wr1_ent
);
    logic [ENT_W-1:0] mem [SETS];

    // Asynchronous read of both probed sets.
    always_comb begin
        rd0_ent = mem[rd0_idx];
        rd1_ent = mem[rd1_idx];
    end

    // Entry updates from the two write ports.
    always_ff @(posedge clk) begin
        if (wr0_en) mem[wr0_idx] <= wr0_ent;
        if (wr1_en) mem[wr1_idx] <= wr1_ent;
    end
endmodule

// File: rtl/cac_ctrl.sv
// Sequencer of the column-associative cache: home lookup, optional partner
// lookup, exchange, relocation, write-back and refill. It also holds the
// per-set valid, dirty and rehash flags and the hit and miss counters.
// Assumes the next level accepts a write-back strobe at any time and answers
// a held fill request with one fill_valid strobe.
module cac_ctrl
    import cac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 7,
    parameter int WSEL_W = 4,
    parameter int WPL    = 16,
    parameter int SETS   = 128,
    parameter int CNT_W  = 32,
    localparam int ETAG_W = ADDR_W - OFF_W - IDX_W + 1,
    localparam int LINE_W = WPL * WORD_W,
    localparam int ENT_W  = ETAG_W + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    input  logic [IDX_W-1:0]  home_idx,
    input  logic [IDX_W-1:0]  alt_idx,
    input  logic [ETAG_W-1:0] ext_tag,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [ENT_W-1:0]  home_ent,
    input  logic [ENT_W-1:0]  alt_ent,
    output logic              wr0_en,
    output logic [IDX_W-1:0]  wr0_idx,
    output logic [ENT_W-1:0]  wr0_ent,
    output logic              wr1_en,
    output logic [IDX_W-1:0]  wr1_idx,
    output logic [ENT_W-1:0]  wr1_ent
);
    cac_state_e        state;
    logic [SETS-1:0]   v_q, d_q, rh_q;
    logic              lat_we, lat_move;
    logic [WORD_W-1:0] lat_wdata;
    logic [CNT_W-1:0]  hit_q, miss_q;
    logic              resp_valid_q, wb_valid_q;
    logic [WORD_W-1:0] resp_rdata_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [LINE_W-1:0] wb_data_q;

    logic [ETAG_W-1:0] home_tag, alt_tag;
    logic [LINE_W-1:0] home_line, alt_line;
    logic              home_hit, alt_hit;

    // Replace one word of a line.
    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s,
                                                   input logic [WORD_W-1:0] w);
        put_word = l;
        put_word[s*WORD_W +: WORD_W] = w;
    endfunction

    // Rebuild a stored line's address from its extended tag and set.
    function automatic logic [ADDR_W-1:0] victim_addr(input logic [ETAG_W-1:0] t,
                                                      input logic [IDX_W-1:0] s);
        victim_addr = {t, s[IDX_W-2:0], {OFF_W{1'b0}}};
    endfunction

    // Unpack both probed entries and compare their tags.
    always_comb begin
        home_tag  = home_ent[ENT_W-1:LINE_W];
        home_line = home_ent[LINE_W-1:0];
        alt_tag   = alt_ent[ENT_W-1:LINE_W];
        alt_line  = alt_ent[LINE_W-1:0];
        home_hit  = v_q[home_idx] && (home_tag == ext_tag);
        alt_hit   = v_q[alt_idx] && (alt_tag == ext_tag);
    end

    // Port-level views of the sequencer state.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        busy       = (state != ST_IDLE);
        fill_req   = (state == ST_REFILL);
        fill_addr  = line_addr;
        resp_valid = resp_valid_q;
        resp_rdata = resp_rdata_q;
        wb_valid   = wb_valid_q;
        wb_addr    = wb_addr_q;
        wb_data    = wb_data_q;
        hit_count  = hit_q;
        miss_count = miss_q;
    end

    // Array write requests for each state.
    always_comb begin
        wr0_en  = 1'b0;
        wr0_idx = home_idx;
        wr0_ent = '0;
        wr1_en  = 1'b0;
        wr1_idx = alt_idx;
        wr1_ent = '0;
        case (state)
            ST_IDLE: begin
                if (req_valid && home_hit && req_we) begin
                    wr0_en  = 1'b1;
                    wr0_ent = {ext_tag, put_word(home_line, wsel, req_wdata)};
                end
            end
            ST_SWAP: begin
                wr0_en  = 1'b1;
                wr0_ent = {alt_tag, lat_we ? put_word(alt_line, wsel, lat_wdata) : alt_line};
                wr1_en  = 1'b1;
                wr1_ent = home_ent;
            end
            ST_EVICT: begin
                if (lat_move && v_q[home_idx]) begin
                    wr1_en  = 1'b1;
                    wr1_ent = home_ent;
                end
            end
            ST_REFILL: begin
                if (fill_valid) begin
                    wr0_en  = 1'b1;
                    wr0_ent = {ext_tag, lat_we ? put_word(fill_data, wsel, lat_wdata) : fill_data};
                end
            end
            default: ;
        endcase
    end

    // Sequencer, flags, counters and registered port strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            v_q          <= '0;
            d_q          <= '0;
            rh_q         <= '1;
            lat_addr     <= '0;
            lat_we       <= 1'b0;
            lat_wdata    <= '0;
            lat_move     <= 1'b0;
            hit_q        <= '0;
            miss_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
            wb_valid_q   <= 1'b0;
            wb_addr_q    <= '0;
            wb_data_q    <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            wb_valid_q   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_addr  <= req_addr;
                        lat_we    <= req_we;
                        lat_wdata <= req_wdata;
                        if (home_hit) begin
                            resp_valid_q <= 1'b1;
                            resp_rdata_q <= home_line[wsel*WORD_W +: WORD_W];
                            if (req_we) d_q[home_idx] <= 1'b1;
                            hit_q <= hit_q + CNT_W'(1);
                        end else if (pa_mode && !rh_q[home_idx]) begin
                            state <= ST_PROBE2;
                        end else begin
                            lat_move <= 1'b0;
                            state    <= ST_EVICT;
                        end
                    end
                end
                ST_PROBE2: begin
                    if (alt_hit) begin
                        state <= ST_SWAP;
                    end else begin
                        lat_move <= 1'b1;
                        state    <= ST_EVICT;
                    end
                end
                ST_SWAP: begin
                    v_q[home_idx]  <= v_q[alt_idx];
                    v_q[alt_idx]   <= v_q[home_idx];
                    d_q[home_idx]  <= d_q[alt_idx] | lat_we;
                    d_q[alt_idx]   <= d_q[home_idx];
                    rh_q[home_idx] <= 1'b0;
                    rh_q[alt_idx]  <= 1'b1;
                    resp_valid_q   <= 1'b1;
                    resp_rdata_q   <= alt_line[wsel*WORD_W +: WORD_W];
                    hit_q          <= hit_q + CNT_W'(1);
                    state          <= ST_IDLE;
                end
                ST_EVICT: begin
                    if (lat_move) begin
                        if (v_q[home_idx]) begin
                            if (v_q[alt_idx] && d_q[alt_idx]) begin
                                wb_valid_q <= 1'b1;
                                wb_addr_q  <= victim_addr(alt_tag, alt_idx);
                                wb_data_q  <= alt_line;
                            end
                            v_q[alt_idx]  <= 1'b1;
                            d_q[alt_idx]  <= d_q[home_idx];
                            rh_q[alt_idx] <= 1'b1;
                        end
                    end else if (v_q[home_idx] && d_q[home_idx]) begin
                        wb_valid_q <= 1'b1;
                        wb_addr_q  <= victim_addr(home_tag, home_idx);
                        wb_data_q  <= home_line;
                    end
                    state <= ST_REFILL;
                end
                ST_REFILL: begin
                    if (fill_valid) begin
                        v_q[home_idx]  <= 1'b1;
                        d_q[home_idx]  <= lat_we;
                        rh_q[home_idx] <= 1'b0;
                        resp_valid_q   <= 1'b1;
                        resp_rdata_q   <= fill_data[wsel*WORD_W +: WORD_W];
                        miss_q         <= miss_q + CNT_W'(1);
                        state          <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr))); // R9
    AST_DM_NO_PROBE2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && !pa_mode && !home_hit) |=> (state == ST_EVICT)); // R7
    AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |=> (!rh_q[$past(home_idx)] && rh_q[$past(alt_idx)])); // R5
    AST_REFILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL && fill_valid) |=> (v_q[$past(home_idx)] && !rh_q[$past(home_idx)])); // R3
    AST_COUNT_PER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q + miss_q) == ($past(hit_q + miss_q) + CNT_W'(resp_valid_q))); // R8
    AST_WB_APART_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid_q && resp_valid_q)); // R6
endmodule

// File: rtl/colassoc_cache.sv
// Column-associative data cache, top level. Wires the address map, the
// line store and the sequencer. The address map sees the incoming request
// while idle and the held request while a miss is being served.
// pa_mode is expected to change only while the cache is idle and holds no
// relocated lines.
module colassoc_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 128,
    parameter int CNT_W      = 32,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int WPL    = LINE_BYTES * 8 / WORD_W,
    localparam int WSEL_W = $clog2(WPL),
    localparam int ETAG_W = ADDR_W - OFF_W - IDX_W + 1,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int ENT_W  = ETAG_W + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic              busy;
    logic [ADDR_W-1:0] lat_addr, map_addr, line_addr;
    logic [IDX_W-1:0]  home_idx, alt_idx;
    logic [ETAG_W-1:0] ext_tag;
    logic [WSEL_W-1:0] wsel;
    logic [ENT_W-1:0]  home_ent, alt_ent;
    logic              wr0_en, wr1_en;
    logic [IDX_W-1:0]  wr0_idx, wr1_idx;
    logic [ENT_W-1:0]  wr0_ent, wr1_ent;

    // Address source: live request when idle, held request otherwise.
    always_comb map_addr = busy ? lat_addr : req_addr;

    cac_addr_map #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_map (
        .addr(map_addr), .home_idx(home_idx), .alt_idx(alt_idx),
        .ext_tag(ext_tag), .wsel(wsel), .line_addr(line_addr)
    );

    cac_line_store #(
        .SETS(SETS), .IDX_W(IDX_W), .ENT_W(ENT_W)
    ) u_store (
        .clk(clk),
        .rd0_idx(home_idx), .rd0_ent(home_ent),
        .rd1_idx(alt_idx),  .rd1_ent(alt_ent),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_ent(wr0_ent),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_ent(wr1_ent)
    );

    cac_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .WPL(WPL), .SETS(SETS), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pa_mode(pa_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_wdata(req_wdata), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .hit_count(hit_count), .miss_count(miss_count),
        .busy(busy), .lat_addr(lat_addr),
        .home_idx(home_idx), .alt_idx(alt_idx), .ext_tag(ext_tag),
        .wsel(wsel), .line_addr(line_addr),
        .home_ent(home_ent), .alt_ent(alt_ent),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_ent(wr0_ent),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_ent(wr1_ent)
    );
endmodule

// File: tb/colassoc_cache_tb.sv
// Scoreboard bench: the driver pushes expected responses and latencies,
// a monitor pops and compares them. The next level is a line memory with
// fixed latency.
module colassoc_cache_tb;
    localparam int LAT   = 3;
    localparam int HIT1  = 0;
    localparam int HIT2  = 2;
    localparam int MISS1 = 2 + LAT;
    localparam int MISS2 = 3 + LAT;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pa_mode = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_we = 1'b0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         fill_req;
    logic [31:0]  fill_addr;
    logic         fill_valid = 1'b0;
    logic [511:0] fill_data = '0;
    logic         wb_valid;
    logic [31:0]  wb_addr;
    logic [511:0] wb_data;
    logic [31:0]  hit_count, miss_count;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wb_cnt = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    logic [31:0]  last_wb = '0;
    logic [31:0]  fa;
    logic [511:0] mem [logic [31:0]];
    logic [31:0]  refw [logic [31:0]];

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        int          lat;
        int          acc;
    } item_t;
    item_t sb_q[$];
    string tag_q[$];

    colassoc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .pa_mode(pa_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [511:0] init_line(input logic [31:0] base);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = init_word(base + 32'(w * 4));
        return l;
    endfunction

    function automatic logic [31:0] mk(input int tg, input int set, input int wd);
        return 32'((tg << 13) | (set << 6) | (wd << 2));
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Next-level line memory: fixed-latency refill.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fill_req) begin
                fa = fill_addr;
                check(fa[5:0] == 6'd0, "R9", "fill address aligned", fa, {fa[31:6], 6'd0});
                repeat (LAT) @(negedge clk);
                fill_data  = mem.exists(fa) ? mem[fa] : init_line(fa);
                fill_valid = 1'b1;
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    // Next-level line memory: write-back capture.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wb_valid) begin
                mem[wb_addr] = wb_data;
                last_wb = wb_addr;
                wb_cnt++;
            end
        end
    end

    // Monitor: pop and compare each response.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "response with nothing outstanding", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    string tg;
                    it = sb_q.pop_front();
                    tg = tag_q.pop_front();
                    check((cyc - it.acc) == it.lat, tg, "latency",
                          32'(cyc - it.acc), 32'(it.lat));
                    if (!it.we)
                        check(resp_rdata == it.data, tg, "read data", resp_rdata, it.data);
                end
            end
        end
    end

    // Driver: issue one access and push its expected result.
    task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                          input int lat, input string tag);
        item_t it;
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = we;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        it.addr = a;
        it.we   = we;
        it.data = refw.exists(a) ? refw[a] : init_word(a);
        it.lat  = lat;
        it.acc  = cyc + 1;
        if (we) refw[a] = wd;
        if (lat == HIT1 || lat == HIT2) exp_hits++;
        else exp_miss++;
        sb_q.push_back(it);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        if (lat != HIT1)
            check(req_ready == 1'b0, "R10", "ready low while miss served", 32'(req_ready), 32'd0);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        finish_up();
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0 && fill_req == 1'b0 && wb_valid == 1'b0, "R1",
              "strobes idle after reset", {29'd0, resp_valid, fill_req, wb_valid}, 32'd0);
        check(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
              hit_count | miss_count, 32'd0);

        // Pseudo-associative mode.
        access(mk(1, 5, 0), 1'b0, '0, MISS1, "R3");          // flag 1 from reset
        access(mk(1, 5, 0), 1'b0, '0, HIT1, "R2");
        access(mk(1, 5, 7), 1'b0, '0, HIT1, "R2");           // back to back
        access(mk(1, 5, 3), 1'b1, 32'hCAFE0001, HIT1, "R2");
        access(mk(1, 5, 3), 1'b0, '0, HIT1, "R2");
        access(mk(2, 5, 1), 1'b0, '0, MISS2, "R6");          // A relocates to set 69
        drain();
        check(wb_cnt == 0, "R6", "no write-back for invalid partner", 32'(wb_cnt), 32'd0);
        access(mk(1, 5, 3), 1'b0, '0, HIT2, "R4");           // exchange
        access(mk(2, 5, 1), 1'b0, '0, HIT2, "R5");           // displaced line found again
        access(mk(3, 5, 2), 1'b0, '0, MISS2, "R6");          // dirty A leaves from set 69
        drain();
        check(wb_cnt == 1, "R6", "write-back count", 32'(wb_cnt), 32'd1);
        check(last_wb == mk(1, 5, 0), "R6", "write-back address", last_wb, mk(1, 5, 0));
        check(mem[mk(1, 5, 0)][3*32 +: 32] == 32'hCAFE0001, "R6", "write-back data",
              mem[mk(1, 5, 0)][3*32 +: 32], 32'hCAFE0001);
        access(mk(4, 69, 0), 1'b0, '0, MISS1, "R3");         // set 69 holds a guest
        drain();
        check(wb_cnt == 1, "R3", "clean guest dropped silently", 32'(wb_cnt), 32'd1);
        access(mk(1, 5, 3), 1'b0, '0, MISS2, "R9");          // refetch written-back data
        access(mk(3, 5, 2), 1'b0, '0, HIT2, "R4");
        drain();

        // Direct-mapped mode on fresh sets.
        pa_mode = 1'b0;
        access(mk(5, 10, 0), 1'b0, '0, MISS1, "R7");
        access(mk(6, 10, 0), 1'b0, '0, MISS1, "R7");
        access(mk(5, 10, 0), 1'b0, '0, MISS1, "R7");         // would be a partner hit
        access(mk(5, 10, 4), 1'b1, 32'hDEADBEEF, HIT1, "R7");
        access(mk(6, 10, 0), 1'b0, '0, MISS1, "R7");
        drain();
        check(wb_cnt == 2, "R7", "dirty victim written back", 32'(wb_cnt), 32'd2);
        check(last_wb == mk(5, 10, 0), "R7", "victim address", last_wb, mk(5, 10, 0));
        access(mk(5, 10, 4), 1'b0, '0, MISS1, "R9");
        access(mk(7, 20, 1), 1'b1, 32'h12345678, MISS1, "R9"); // write allocate
        access(mk(7, 20, 1), 1'b0, '0, HIT1, "R9");
        drain();

        check(hit_count == 32'(exp_hits), "R8", "hit counter", hit_count, 32'(exp_hits));
        check(miss_count == 32'(exp_miss), "R8", "miss counter", miss_count, 32'(exp_miss));
        finish_up();
    end
endmodule